// File: doc/BRIEF.md
# Three-Cluster Barrier Synchronizer

This block joins the threads of three processing clusters at hardware barriers. Every cluster runs a fixed number of hardware thread slots, and each slot owns an independent barrier. When the issue stage of a cluster reports that a thread has executed a barrier instruction, the synchronizer holds that thread with a level stall signal. The stalled thread issues nothing and does not poll. It is released by a one-cycle pulse once the same slot on the other two clusters has reached the barrier as well.

The clusters exchange state over two global wires per cluster and slot, six per slot in all. The reach wire is high while the cluster waits at the barrier. The generation wire carries the parity of the barriers that cluster has completed. A cluster compares the generation it sees on its peers with its own. If a peer is one generation ahead, that peer has already passed the current barrier. If a peer shows the previous generation, the prior barrier is still draining, and a new arrival is parked until it finishes. With this rule back-to-back barriers cannot mix, even when the wires between clusters are pipelined.

With unregistered wires, a barrier whose last arrival appears in a cycle releases all three threads in that same cycle. A slot can therefore complete one barrier every cycle.

Top module: `bar3_sync`

## Requirements
- R1: After reset every output is 0: hold, release, reach wire and generation wire, for all clusters and slots.
- R2: A cluster's release pulse for slot t occurs only when, for the current barrier, slot t on both other clusters has arrived. Each barrier gives exactly one release pulse per cluster.
- R3: From its arrival cycle until the cycle before its release, a thread sees hold = 1. In the release cycle hold = 0 and release = 1. Hold and release are never 1 together.
- R4: With LINK_STAGES = 0, all three clusters of a slot are released in the cycle in which the last of them arrives (arrival and release in the same cycle).
- R5: With LINK_STAGES = 0 and arrivals from all three clusters in every cycle, every slot completes a barrier in every cycle.
- R6: Slots are independent. Activity on slot t never changes the outputs of any other slot.
- R7: The reach wire of a cluster and slot is 1 from the arrival cycle through the release cycle inclusive, and 0 otherwise. The generation wire starts at 0 and inverts on the clock edge that ends each release cycle.
- R8: An arrival seen while any peer's visible generation differs from the cluster's own is parked. During that time hold = 1 and reach = 0. It is admitted, with reach = 1, once the generations match.
- R9: An arrival pulse on a cluster that is already waiting is ignored. It creates no extra barrier, and the thread is not held after its release.
- R10: With LINK_STAGES = 1, the clusters stay in lockstep. The k-th release of a cluster never comes before all three clusters have issued their k-th arrival, and all clusters complete the same number of barriers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bar_arrive_i | input | 3 x NTHR | One-cycle pulse: the thread in slot [t] of cluster [c] executed a barrier |
| bar_hold_o | output | 3 x NTHR | Thread is stalled at the barrier |
| bar_go_o | output | 3 x NTHR | One-cycle release pulse |
| wire_reach_o | output | 3 x NTHR | Global reach wire driven by each cluster |
| wire_gen_o | output | 3 x NTHR | Global generation-parity wire driven by each cluster |

## Verification
The bench builds two instances. The first uses the default configuration: five slots and unregistered links. On every slot it sweeps all 27 combinations of arrival cycles 0 to 2 for the three clusters, once with single pulses and once with repeated pulses while waiting, and checks release timing, hold, reach, generation and slot isolation in every cycle. The second instance has two slots and LINK_STAGES = 1. Only there can a cluster see a stale peer generation, so that instance reaches the parked-arrival path of R8. It gets one scripted sequence with exact cycles, followed by a long pseudo-random run in which the bench counts arrivals and releases per cluster to check lockstep.

// File: rtl/bar_pkg.sv
`timescale 1ns/1ps
package bar_pkg;
   localparam int unsigned BAR_NCL = 3;
   localparam int unsigned BAR_MAX_STAGES = 4;
   localparam int unsigned BAR_MAX_THR = 64;
   typedef logic [BAR_NCL-1:0] clmask_t;
endpackage

// File: rtl/bar_link.sv
`timescale 1ns/1ps
module bar_link #(
   parameter int unsigned W = 6,
   parameter int unsigned STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES > bar_pkg::BAR_MAX_STAGES) begin : g_bad
         $error("bar_link: STAGES out of range");
      end
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_pipe
         logic [W-1:0] stg [STAGES+1];
         assign stg[0] = d_i;
         for (genvar s = 0; s < STAGES; s++) begin : g_stg
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s+1] <= '0;
               else        stg[s+1] <= stg[s];
            end
         end
         assign q_o = stg[STAGES];
      end
   endgenerate
endmodule

// File: rtl/bar_node.sv
`timescale 1ns/1ps
module bar_node #(
   parameter int unsigned NCL = 3,
   parameter int unsigned ME  = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arrive_i,
   input  logic [NCL-1:0] view_reach_i,
   input  logic [NCL-1:0] view_gen_i,
   output logic           hold_o,
   output logic           go_o,
   output logic           reach_o,
   output logic           gen_o
);
   logic waiting_q, pending_q, gen_q;
   logic peers_eq, peers_ok, admit, w_eff, want;

   generate
      if (ME >= NCL) begin : g_bad
         $error("bar_node: ME out of range");
      end
   endgenerate

   always_comb begin
      peers_eq = 1'b1;
      peers_ok = 1'b1;
      for (int j = 0; j < NCL; j++) begin
         if (j != ME) begin
            if (view_gen_i[j] != gen_q) peers_eq = 1'b0;
            if (!((view_gen_i[j] != gen_q) || view_reach_i[j])) peers_ok = 1'b0;
         end
      end
   end

   assign want    = arrive_i | pending_q;
   assign admit   = want & ~waiting_q & peers_eq;
   assign w_eff   = waiting_q | admit;
   assign go_o    = w_eff & peers_ok;
   assign hold_o  = (want | waiting_q) & ~go_o;
   assign reach_o = w_eff;
   assign gen_o   = gen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting_q <= 1'b0;
         pending_q <= 1'b0;
         gen_q     <= 1'b0;
      end else begin
         waiting_q <= w_eff & ~go_o;
         pending_q <= want & ~waiting_q & ~admit;
         gen_q     <= gen_q ^ go_o;
      end
   end

   a_r3_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_o && hold_o));
   a_r3_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
      waiting_q |-> (hold_o || go_o));
   a_r7_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
      go_o |=> (gen_q != $past(gen_q)));
   a_r8_pend_excl: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q |-> !waiting_q);
   a_r9_no_double: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_q && arrive_i && !go_o) |=> (waiting_q && !pending_q));
endmodule

// File: rtl/bar_slot.sv
`timescale 1ns/1ps
module bar_slot #(
   parameter int unsigned LINK_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bar_pkg::clmask_t arrive_i,
   output bar_pkg::clmask_t hold_o,
   output bar_pkg::clmask_t go_o,
   output bar_pkg::clmask_t reach_o,
   output bar_pkg::clmask_t gen_o
);
   localparam int unsigned NCL = bar_pkg::BAR_NCL;
   bar_pkg::clmask_t view_reach, view_gen;

   bar_link #(.W(2*NCL), .STAGES(LINK_STAGES)) link_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({reach_o, gen_o}),
      .q_o  ({view_reach, view_gen})
   );

   generate
      for (genvar c = 0; c < NCL; c++) begin : g_cl
         bar_node #(.NCL(NCL), .ME(c)) node_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .arrive_i    (arrive_i[c]),
            .view_reach_i(view_reach),
            .view_gen_i  (view_gen),
            .hold_o      (hold_o[c]),
            .go_o        (go_o[c]),
            .reach_o     (reach_o[c]),
            .gen_o       (gen_o[c])
         );
      end
      if (LINK_STAGES == 0) begin : g_chk0
         a_r4_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
            (|go_o) |-> (&go_o));
         a_r2_gen_agree: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_o == '0) || (gen_o == '1));
      end
   endgenerate
endmodule

// File: rtl/bar3_sync.sv
`timescale 1ns/1ps
module bar3_sync #(
   parameter int unsigned NTHR = 5,
   parameter int unsigned LINK_STAGES = 0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [bar_pkg::BAR_NCL-1:0][NTHR-1:0] bar_arrive_i,
   output logic [bar_pkg::BAR_NCL-1:0][NTHR-1:0] bar_hold_o,
   output logic [bar_pkg::BAR_NCL-1:0][NTHR-1:0] bar_go_o,
   output logic [bar_pkg::BAR_NCL-1:0][NTHR-1:0] wire_reach_o,
   output logic [bar_pkg::BAR_NCL-1:0][NTHR-1:0] wire_gen_o
);
   localparam int unsigned NCL = bar_pkg::BAR_NCL;

   generate
      if (NTHR < 1 || NTHR > bar_pkg::BAR_MAX_THR) begin : g_bad_thr
         $error("bar3_sync: NTHR out of range");
      end
      if (LINK_STAGES > bar_pkg::BAR_MAX_STAGES) begin : g_bad_stg
         $error("bar3_sync: LINK_STAGES out of range");
      end
      for (genvar t = 0; t < NTHR; t++) begin : g_slot
         bar_pkg::clmask_t arr, hld, go, rch, gen;
         for (genvar c = 0; c < NCL; c++) begin : g_map
            assign arr[c]             = bar_arrive_i[c][t];
            assign bar_hold_o[c][t]   = hld[c];
            assign bar_go_o[c][t]     = go[c];
            assign wire_reach_o[c][t] = rch[c];
            assign wire_gen_o[c][t]   = gen[c];
         end
         bar_slot #(.LINK_STAGES(LINK_STAGES)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .arrive_i(arr),
            .hold_o  (hld),
            .go_o    (go),
            .reach_o (rch),
            .gen_o   (gen)
         );
      end
   endgenerate

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bar_go_o == '0 && wire_gen_o == '0));
endmodule

// File: tb/bar3_sync_tb_top.sv
`timescale 1ns/1ps
module bar3_sync_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [2:0][4:0] arr, hold, go, reach, gen;
   logic [2:0][1:0] arr_d, hold_d, go_d, reach_d, gen_d;

   bar3_sync #(.NTHR(5), .LINK_STAGES(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bar_arrive_i(arr), .bar_hold_o(hold),
      .bar_go_o(go), .wire_reach_o(reach), .wire_gen_o(gen));
   bar3_sync #(.NTHR(2), .LINK_STAGES(1)) dut_d (
      .clk(clk), .rst_n(rst_n), .bar_arrive_i(arr_d), .bar_hold_o(hold_d),
      .bar_go_o(go_d), .wire_reach_o(reach_d), .wire_gen_o(gen_d));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act == exp, req, act, exp);
   endtask

   logic [4:0] par;
   logic [2:0][4:0] e_go, e_hold, e_reach, e_gen;
   int iss [3][2];
   int rel [3][2];
   bit busy [3][2];
   logic [15:0] lfsr;

   initial begin
      arr = '0; arr_d = '0; par = '0;
      #35 rst_n = 1'b1;
      @(negedge clk);
      #5;
      // R1 reset state
      cmp("R1 hold", 32'(hold), 0);
      cmp("R1 go", 32'(go), 0);
      cmp("R1 reach", 32'(reach), 0);
      cmp("R1 gen", 32'(gen), 0);
      cmp("R1 dly outputs", 32'({hold_d, go_d, reach_d, gen_d}), 0);

      // R2 R3 R4 R6 R7 R9: sweep of arrival offsets on every slot
      for (int t = 0; t < 5; t++) begin
         for (int dup = 0; dup < 2; dup++) begin
            for (int code = 0; code < 27; code++) begin
               int d [3];
               int mx;
               d[0] = code % 3; d[1] = (code / 3) % 3; d[2] = code / 9;
               mx = d[0];
               if (d[1] > mx) mx = d[1];
               if (d[2] > mx) mx = d[2];
               for (int cyc = 0; cyc <= mx + 1; cyc++) begin
                  @(negedge clk);
                  arr = '0;
                  e_go = '0; e_hold = '0; e_reach = '0;
                  for (int c = 0; c < 3; c++) begin
                     arr[c][t] = (cyc == d[c]) || (dup == 1 && cyc > d[c] && cyc <= mx);
                     e_go[c][t]    = (cyc == mx);
                     e_hold[c][t]  = (cyc >= d[c]) && (cyc < mx);
                     e_reach[c][t] = (cyc >= d[c]) && (cyc <= mx);
                     e_gen[c]      = par;
                  end
                  #5;
                  cmp("R2 R4 R6 go", 32'(go), 32'(e_go));
                  cmp("R3 R9 hold", 32'(hold), 32'(e_hold));
                  cmp("R7 reach", 32'(reach), 32'(e_reach));
                  cmp("R7 gen", 32'(gen), 32'(e_gen));
                  if (cyc == mx) par[t] = ~par[t];
               end
            end
         end
      end

      // R5: a barrier every cycle on every slot
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         arr = '1;
         #5;
         cmp("R5 go", 32'(go), 32'({3{5'h1f}}));
         cmp("R5 hold", 32'(hold), 0);
         cmp("R5 gen", 32'(gen), 32'({3{par}}));
         par = ~par;
      end
      @(negedge clk);
      arr = '0;

      // R8 R10: scripted sequence on the registered-link instance, slot 0
      @(negedge clk); arr_d = '0; arr_d[0][0] = 1; arr_d[1][0] = 1; arr_d[2][0] = 1;
      #5 cmp("R10 no early go", 32'(go_d), 0);
      cmp("R3 hold dly", 32'({hold_d[2][0], hold_d[1][0], hold_d[0][0]}), 7);
      @(negedge clk); arr_d = '0;
      #5 cmp("R10 go dly", 32'({go_d[2][0], go_d[1][0], go_d[0][0]}), 7);
      @(negedge clk); arr_d = '0; arr_d[0][0] = 1;
      #5 cmp("R8 parked hold", 32'(hold_d[0][0]), 1);
      cmp("R8 parked reach", 32'(reach_d[0][0]), 0);
      cmp("R7 gen dly", 32'({gen_d[2][0], gen_d[1][0], gen_d[0][0]}), 7);
      @(negedge clk); arr_d = '0;
      #5 cmp("R8 admitted reach", 32'(reach_d[0][0]), 1);
      cmp("R8 admitted hold", 32'(hold_d[0][0]), 1);
      @(negedge clk); arr_d = '0; arr_d[1][0] = 1; arr_d[2][0] = 1;
      #5 cmp("R10 wait peers", 32'(go_d), 0);
      @(negedge clk); arr_d = '0;
      #5 cmp("R10 second go", 32'({go_d[2][0], go_d[1][0], go_d[0][0]}), 7);
      @(negedge clk); arr_d = '0;

      // R10: pseudo-random lockstep run on both slots
      for (int c = 0; c < 3; c++)
         for (int t = 0; t < 2; t++) begin
            iss[c][t] = 0; rel[c][t] = 0; busy[c][t] = 0;
         end
      lfsr = 16'hace1;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         arr_d = '0;
         for (int c = 0; c < 3; c++)
            for (int t = 0; t < 2; t++) begin
               int mxi;
               mxi = iss[0][t];
               if (iss[1][t] > mxi) mxi = iss[1][t];
               if (iss[2][t] > mxi) mxi = iss[2][t];
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               if (!busy[c][t] && (k < 500 ? lfsr[0] : (iss[c][t] < mxi))) begin
                  arr_d[c][t] = 1'b1;
                  busy[c][t] = 1'b1;
                  iss[c][t]++;
               end
            end
         #5;
         for (int c = 0; c < 3; c++)
            for (int t = 0; t < 2; t++) begin
               if (go_d[c][t]) begin
                  int mn;
                  rel[c][t]++;
                  mn = iss[0][t];
                  if (iss[1][t] < mn) mn = iss[1][t];
                  if (iss[2][t] < mn) mn = iss[2][t];
                  chk(busy[c][t] && rel[c][t] <= mn, "R10 release order",
                      32'(rel[c][t]), 32'(mn));
                  busy[c][t] = 1'b0;
               end else if (busy[c][t]) begin
                  chk(hold_d[c][t] == 1'b1, "R3 waiting held", 32'(hold_d[c][t]), 1);
               end
            end
      end
      for (int t = 0; t < 2; t++)
         for (int c = 0; c < 3; c++) begin
            cmp("R10 all released", 32'(rel[c][t]), 32'(iss[c][t]));
            cmp("R10 equal counts", 32'(rel[c][t]), 32'(rel[0][t]));
         end
      chk(rel[0][0] > 20 && rel[0][1] > 20, "R10 progress", 32'(rel[0][0]), 21);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule